// File: doc/BRIEF.md
# Nine-Bit Rate-Buffer FIFO with Replay

This block is a first-in/first-out store of nine-bit words. It sits between a producer and a consumer that run at different rates. Each word carries eight data bits plus one spare bit, which the user may spend on parity or a control mark. No address is ever supplied. An active-low write strobe stores the word on the input bus, and an active-low read strobe presents the oldest stored word. Two internal ring positions advance one step on each accepted access. Both strobes are sampled on the rising edge of a single clock, and a read and a write may land on the same edge.

Three status outputs report the occupancy: empty, full and half-full. Writes that would overflow and reads that would underflow are refused.

An active-low replay input rewinds only the read position to the first location. Everything written since the last reset can then be read out again, while the write position keeps its place. Replay is meaningful only while fewer words than the depth have been written since reset. The depth is a power-of-two parameter; the intended values are 512, 1024, 2048, 4096, 8192 and 16384, and the default is 512.

Top module: `rate_fifo9`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises, empty is 1, full is 0, half is 0 and rdata is 0.
- R2: Words come out on rdata in the order they were written, with all nine bits intact. rdata changes on the clock edge that accepts a read, so it can be sampled in the following cycle. With rd_n high, rdata holds its value.
- R3: full is 1 exactly when DEPTH words are stored. A write strobe on an edge where full is 1 stores nothing and leaves the occupancy unchanged.
- R4: empty is 1 exactly when no word is stored. A read strobe on an edge where empty is 1 is ignored, and rdata keeps its previous value.
- R5: A read and a write on the same edge are both performed when the FIFO is neither empty nor full, which leaves the occupancy unchanged. When it is empty, only the write is performed. When it is full, only the read is performed.
- R6: half is 1 exactly when the occupancy is at least DEPTH/2.
- R7: rewind_n low on an edge sets the read position to the first location written after reset. It also sets the occupancy to the number of words written since reset. A read strobe on that same edge is ignored. This holds only while fewer than DEPTH words have been written since reset.
- R8: Replay does not move the write position. A write on the replay edge is stored and counted, and later writes append after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of positions, occupancy and output word |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rewind_n | input | 1 | Active-low replay request; rewinds the read position |
| wdata | input | 9 | Word to store |
| rdata | output | 9 | Last word read |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| half | output | 1 | At least DEPTH/2 words stored |

## Verification
The hardest state to reach from the ports is a replay that lands after part of the data has been drained, with a read and a write strobed on the very same edge. That edge must drop the read, store the write and restore an occupancy equal to all words written since reset. The stimulus gets there after a fresh reset: it writes a short run, reads part of it, then pulses rewind_n with both strobes low. A randomised phase follows that allows replay only while the number of writes since reset stays below the depth. The full-to-empty boundary also needs the whole 512-word default depth to be filled and drained, with refused strobes offered at both ends.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rf_ctrl.sv
// Position and occupancy control for the replay FIFO.
module rf_ctrl #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          rew_req,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wpos,
    output logic [AW-1:0] rpos,
    output logic [CW-1:0] occ
);
    typedef struct packed {
        logic [AW-1:0] wpos;
        logic [AW-1:0] rpos;
        logic [CW-1:0] occ;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_go = wr_req && (st_q.occ != CW'(DEPTH));
        rd_go = rd_req && !rew_req && (st_q.occ != '0);
        if (wr_go) begin
            st_d.wpos = st_q.wpos + 1'b1;
        end
        if (rd_go) begin
            st_d.rpos = st_q.rpos + 1'b1;
        end
        if (rew_req) begin
            st_d.rpos = '0;
            st_d.occ  = {1'b0, st_d.wpos};
        end else begin
            unique case ({wr_go, rd_go})
                2'b10:   st_d.occ = st_q.occ + 1'b1;
                2'b01:   st_d.occ = st_q.occ - 1'b1;
                default: st_d.occ = st_q.occ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wpos = st_q.wpos;
    assign rpos = st_q.rpos;
    assign occ  = st_q.occ;
endmodule

// File: rtl/rf_store.sv
// Word array with a registered output word.
module rf_store #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  rf_pkg::word_t wdata,
    input  logic          rd_en,
    input  logic [AW-1:0] raddr,
    output rf_pkg::word_t rdata
);
    rf_pkg::word_t mem [DEPTH];
    rf_pkg::word_t out_d, out_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        out_d = out_q;
        if (rd_en) begin
            out_d = mem[raddr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata = out_q;
endmodule

// File: rtl/rf_flags.sv
// Status decode from the registered occupancy.
module rf_flags #(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] occ,
    output logic          empty,
    output logic          full,
    output logic          half
);
    localparam logic [CW-1:0] FULL_AT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_AT = CW'(DEPTH / 2);

    always_comb begin
        empty = (occ == '0);
        full  = (occ == FULL_AT);
        half  = (occ >= HALF_AT);
    end
endmodule

// File: rtl/rate_fifo9.sv
// Nine-bit FIFO with replay and half-full status.
module rate_fifo9 #(
    parameter int DEPTH = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic       rewind_n,
    input  logic [8:0] wdata,
    output logic [8:0] rdata,
    output logic       empty,
    output logic       full,
    output logic       half
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          wr_go, rd_go;
    logic [AW-1:0] wpos, rpos;
    logic [CW-1:0] occ;

    rf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (!wr_n),
        .rd_req  (!rd_n),
        .rew_req (!rewind_n),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .wpos    (wpos),
        .rpos    (rpos),
        .occ     (occ)
    );

    rf_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_go),
        .waddr (wpos),
        .wdata (wdata),
        .rd_en (rd_go),
        .raddr (rpos),
        .rdata (rdata)
    );

    rf_flags #(.DEPTH(DEPTH)) u_flags (
        .occ   (occ),
        .empty (empty),
        .full  (full),
        .half  (half)
    );
endmodule

// File: rtl/rf_checker.sv
// Port-level properties for rate_fifo9.
module rf_checker #(
    parameter int DEPTH = 512
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_n,
    input logic       rd_n,
    input logic       rewind_n,
    input logic [8:0] rdata,
    input logic       empty,
    input logic       full,
    input logic       half
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty && !full && !half && rdata == 9'd0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> $stable(rdata));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_n && rewind_n) |=> full);

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rewind_n) |=> $stable(rdata));

    assert_stay_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr_n && rewind_n) |=> empty);

    assert_steady_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && !wr_n && !rd_n && rewind_n)
            |=> ($stable(empty) && $stable(full) && $stable(half)));

    assert_full_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half && !empty));

    assert_empty_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !half);

    assert_rewind_noread_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind_n |=> $stable(rdata));
endmodule

bind rate_fifo9 rf_checker #(.DEPTH(DEPTH)) u_rf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .rewind_n (rewind_n),
    .rdata    (rdata),
    .empty    (empty),
    .full     (full),
    .half     (half)
);

// File: tb/rate_fifo9_test.sv
module rate_fifo9_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int WATCHDOG   = 150000;

    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic       wr_n     = 1'b1;
    logic       rd_n     = 1'b1;
    logic       rewind_n = 1'b1;
    logic [8:0] wdata    = '0;
    logic [8:0] rdata;
    logic       empty, full, half;

    rate_fifo9 #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
        .rewind_n(rewind_n), .wdata(wdata), .rdata(rdata),
        .empty(empty), .full(full), .half(half)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: every word since reset, plus a read index.
    logic [8:0] hist[$];
    int         ridx = 0;
    logic [8:0] q_m  = '0;

    always @(posedge clk) begin
        int  cnt;
        bit  wgo, rgo;
        if (!rst_n) begin
            hist.delete();
            ridx = 0;
            q_m  = '0;
        end else begin
            cnt = hist.size() - ridx;
            wgo = !wr_n && cnt < DEPTH;
            rgo = !rd_n && rewind_n && cnt > 0;
            if (rgo) begin
                q_m  = hist[ridx];
                ridx = ridx + 1;
            end
            if (wgo) hist.push_back(wdata);
            if (!rewind_n) ridx = 0;
        end
    end

    int    vectors = 0;
    int    misses  = 0;
    int    cycles  = 0;
    bit    done    = 0;
    string tag     = "R1";

    task automatic cmp1(input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            misses++;
            $display("FAIL %s %s got %0h expected %0h at cycle %0d", tag, what, got, exp, cycles);
        end
    endtask

    task automatic check_all();
        int cnt;
        cnt = hist.size() - ridx;
        cmp1("empty", int'(empty), int'(cnt == 0));
        cmp1("full",  int'(full),  int'(cnt == DEPTH));
        cmp1("half",  int'(half),  int'(cnt >= DEPTH/2));
        cmp1("rdata", int'(rdata), int'(q_m));
    endtask

    task automatic step(input bit w, input bit r, input bit rw, input logic [8:0] d);
        wr_n = !w; rd_n = !r; rewind_n = !rw; wdata = d;
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(0, 0, 0, '0);
        step(0, 0, 0, '0);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            misses++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then first edge after release
        tag = "R1";
        @(negedge clk);
        do_reset();
        cmp1("rdata after reset", int'(rdata), 0);
        step(0, 0, 0, '0);

        // R2: order and nine-bit integrity, idle hold
        tag = "R2";
        step(1, 0, 0, 9'h1AB);
        step(1, 0, 0, 9'h055);
        step(1, 0, 0, 9'h100);
        step(1, 0, 0, 9'h0FF);
        for (int i = 0; i < 4; i++) step(0, 1, 0, '0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 9'h1FF);
        cmp1("rdata last word", int'(rdata), 9'h0FF);

        // R6 and R3: fill through half to full
        tag = "R6";
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 9'(i * 7) ^ 9'h155);
        tag = "R3";
        cmp1("full at DEPTH", int'(full), 1);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 9'h1EE);
        // R5 on full: only the read happens
        tag = "R5";
        step(1, 1, 0, 9'h1DD);
        step(1, 0, 0, 9'h0A5);
        tag = "R3";
        step(1, 0, 0, 9'h111);

        // R4: drain and keep reading past empty
        tag = "R4";
        for (int i = 0; i < DEPTH + 5; i++) step(0, 1, 0, '0);
        cmp1("empty after drain", int'(empty), 1);

        // R5: simultaneous access when partly filled, and when empty
        tag = "R5";
        step(1, 1, 0, 9'h013);
        step(0, 0, 0, '0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 9'(i + 9'h040));
        for (int i = 0; i < 40; i++) step(1, 1, 0, 9'(i * 13));
        for (int i = 0; i < 5; i++) step(0, 1, 0, '0);

        // R7: replay after a partial drain, read on the replay edge dropped
        tag = "R7";
        do_reset();
        for (int i = 0; i < 10; i++) step(1, 0, 0, 9'(9'h180 + i));
        for (int i = 0; i < 6; i++) step(0, 1, 0, '0);
        step(0, 1, 1, '0);
        for (int i = 0; i < 11; i++) step(0, 1, 0, '0);
        cmp1("empty after replay drain", int'(empty), 1);

        // R8: write on the replay edge, later writes append
        tag = "R8";
        step(0, 1, 1, '0);
        step(1, 1, 1, 9'h1C3);
        step(1, 0, 0, 9'h0C4);
        for (int i = 0; i < 13; i++) step(0, 1, 0, '0);
        cmp1("rdata appended word", int'(rdata), 9'h0C4);

        // Random mix covering R2 through R8
        tag = "R2";
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            bit w, r, rw;
            w  = ($urandom_range(0, 99) < 55);
            r  = ($urandom_range(0, 99) < 50);
            rw = ($urandom_range(0, 39) == 0) && (hist.size() < DEPTH - 1);
            tag = rw ? "R7" : "R2";
            step(w, r, rw, 9'($urandom));
            if (hist.size() > 3 * DEPTH) do_reset();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule